// File: doc/BRIEF.md
# Sleep and Wake Power Controller

This block picks between an active and a sleep mode for a battery-pack monitor. It watches the single-wire host bus line and the output of an undervoltage comparator. It also takes a 1 µs timebase tick and two configuration bits: a sleep enable and an undervoltage sleep enable. Two independent tick-counted dwell timers supply the sleep triggers. The first fires when the bus has been held low long enough to mean the pack was disconnected. The second fires when the cell voltage has stayed under the threshold long enough to mean the cell is depleted. A return to active mode needs a low-to-high transition on the bus while the voltage is healthy.

A measurement-enable output tells the converters when to run. The block also owns the control latch of a programmable open-drain pin. Writing 0 pulls the pin low. Writing 1 releases it. The readback bit is the synchronized pin level. In sleep, or during any long bus-low period even with sleep disabled, the pin is forced to release and the latch is set to 1.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the block is active: `meas_en_o`=1, `sleep_o`=0, `pio_pull_o`=0, and the pin latch holds 1.
- R2: With `pmod_i`=1, the block enters sleep once the synchronized bus has stayed low for BUS_LOW_TICKS tick pulses. Fewer ticks keep it active.
- R3: With `pmod_i`=0 the block never enters sleep, whatever the bus or the voltage does.
- R4: With `pmod_i`=1 and `uven_i`=1, the block enters sleep once `uv_low_i`=1 has held for UV_TICKS tick pulses. With `uven_i`=0, undervoltage never causes sleep.
- R5: Each dwell count restarts from zero when its condition lapses before expiry. Two short episodes do not add up.
- R6: In sleep, the block wakes only on a synchronized low-to-high transition of the bus while `uv_low_i`=0. A bus edge during undervoltage leaves it asleep, and so does healthy voltage without an edge.
- R7: `meas_en_o` is 1 exactly when the block is active.
- R8: A write with data 0 makes `pio_pull_o`=1. A write with data 1 makes it 0. `pio_rdata_o` returns the pin level after SYNC_STAGES clocks.
- R9: While asleep, or while the bus-low dwell has expired (whatever `pmod_i` is), `pio_pull_o`=0, the latch is set to 1 and writes are ignored.
- R10: After a forced release ends, the pin stays released until software writes 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per microsecond of the timebase |
| bus_i | input | 1 | Host bus line level (asynchronous) |
| uv_low_i | input | 1 | Comparator flag, 1 = voltage under threshold (asynchronous) |
| pmod_i | input | 1 | Sleep enable |
| uven_i | input | 1 | Undervoltage sleep enable |
| pio_wr_i | input | 1 | Write strobe for the pin latch |
| pio_wdata_i | input | 1 | Pin latch write data (0 = pull low) |
| pio_pin_i | input | 1 | Sensed pin level (asynchronous) |
| meas_en_o | output | 1 | Measurement enable, high in active mode |
| sleep_o | output | 1 | High in sleep mode |
| pio_pull_o | output | 1 | Open-drain pull-down enable for the pin |
| pio_rdata_o | output | 1 | Synchronized pin level for readback |

## Verification
The hardest state to reach is sleep caused by undervoltage while the bus sits high. From there, a bus edge alone or healthy voltage alone must not wake the block. The bench reaches that state by holding the comparator flag for a counted number of ticks. It then first pulses the bus while the flag is still set, and next clears the flag without pulsing the bus, checking that the block is still asleep after each step. Dwell thresholds are swept tick by tick across every configuration pair. The bench drives the tick directly, so the expected mode for each count is exact.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [0:0] {
        MODE_ACTIVE = 1'b0,
        MODE_SLEEP  = 1'b1
    } mode_e;

    typedef struct packed {
        logic bus;
        logic uv;
        logic pin;
    } pad_s;

    localparam pad_s PAD_RST = '{bus: 1'b1, uv: 1'b0, pin: 1'b1};

    function automatic mode_e mode_step(
        mode_e cur,
        logic  pmod,
        logic  uven,
        logic  buslow_done,
        logic  uv_done,
        logic  bus_rise,
        logic  uv_now
    );
        mode_e nxt;
        nxt = cur;
        case (cur)
            MODE_ACTIVE: if (pmod && (buslow_done || (uven && uv_done))) nxt = MODE_SLEEP;
            MODE_SLEEP:  if (bus_rise && !uv_now) nxt = MODE_ACTIVE;
            default:     nxt = MODE_ACTIVE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_dwell_timer.sv
module pwr_dwell_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic hold_i,
    output logic expired_o
);
    localparam int          CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !hold_i)                cnt_q <= '0;
        else if (tick_i && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/pwr_pio_ctl.sv
module pwr_pio_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic force_i,
    output logic pull_o
);
    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst)          latch_q <= 1'b1;
        else if (force_i) latch_q <= 1'b1;
        else if (wr_i)    latch_q <= wdata_i;
    end

    assign pull_o = !latch_q && !force_i;
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int BUS_LOW_TICKS = 2_200_000,
    parameter int UV_TICKS      = 100_000,
    parameter int SYNC_STAGES   = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic bus_i,
    input  logic uv_low_i,
    input  logic pmod_i,
    input  logic uven_i,
    input  logic pio_wr_i,
    input  logic pio_wdata_i,
    input  logic pio_pin_i,
    output logic meas_en_o,
    output logic sleep_o,
    output logic pio_pull_o,
    output logic pio_rdata_o
);
    localparam int PW = $bits(pad_s);

    pad_s  pad_raw, pad_syn;
    logic  bus_s, uv_s, bus_prev_q, bus_rise;
    logic  bus_low_exp, uv_exp, pio_force;
    mode_e mode_q, mode_d;

    assign pad_raw = '{bus: bus_i, uv: uv_low_i, pin: pio_pin_i};

    pwr_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PAD_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pad_raw),
        .q_o (pad_syn)
    );

    assign bus_s = pad_syn.bus;
    assign uv_s  = pad_syn.uv;

    always_ff @(posedge clk) begin
        if (rst) bus_prev_q <= 1'b1;
        else     bus_prev_q <= bus_s;
    end
    assign bus_rise = bus_s && !bus_prev_q;

    pwr_dwell_timer #(.LIMIT(BUS_LOW_TICKS)) u_buslow (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .hold_i    (!bus_s),
        .expired_o (bus_low_exp)
    );

    pwr_dwell_timer #(.LIMIT(UV_TICKS)) u_uvdwell (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .hold_i    (uv_s),
        .expired_o (uv_exp)
    );

    assign mode_d = mode_step(mode_q, pmod_i, uven_i, bus_low_exp, uv_exp, bus_rise, uv_s);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_ACTIVE;
        else     mode_q <= mode_d;
    end

    assign pio_force = (mode_q == MODE_SLEEP) || bus_low_exp;

    pwr_pio_ctl u_pio (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (pio_wr_i),
        .wdata_i (pio_wdata_i),
        .force_i (pio_force),
        .pull_o  (pio_pull_o)
    );

    assign meas_en_o   = (mode_q == MODE_ACTIVE);
    assign sleep_o     = (mode_q == MODE_SLEEP);
    assign pio_rdata_o = pad_syn.pin;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
    input logic clk,
    input logic rst,
    input logic pmod_i,
    input logic sleep_o,
    input logic pio_pull_o,
    input logic bus_s,
    input logic uv_s,
    input logic bus_low_exp
);
    AST_SLEEP_NEEDS_PMOD: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> $past(pmod_i)); // R3

    AST_WAKE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_o) |-> ($past(bus_s) && !$past(bus_s, 2))); // R6

    AST_WAKE_NEEDS_HEALTHY: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_o) |-> !$past(uv_s)); // R6

    AST_SLEEP_RELEASES_PIN: assert property (@(posedge clk) disable iff (rst)
        sleep_o |-> !pio_pull_o); // R9

    AST_LONG_LOW_RELEASES_PIN: assert property (@(posedge clk) disable iff (rst)
        bus_low_exp |-> !pio_pull_o); // R9
endmodule

bind pwr_mode_ctl pwr_mode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pmod_i      (pmod_i),
    .sleep_o     (sleep_o),
    .pio_pull_o  (pio_pull_o),
    .bus_s       (bus_s),
    .uv_s        (uv_s),
    .bus_low_exp (bus_low_exp)
);

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
    localparam int BL = 5;
    localparam int UV = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, bus = 1, uvl = 0, pmod = 0, uven = 0, wr = 0, wdata = 1, ext = 1;
    logic meas_en, sleep, pull, rdata, pin;
    int   n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    assign pin = ext & ~pull;

    pwr_mode_ctl #(.BUS_LOW_TICKS(BL), .UV_TICKS(UV)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .bus_i(bus), .uv_low_i(uvl),
        .pmod_i(pmod), .uven_i(uven), .pio_wr_i(wr), .pio_wdata_i(wdata),
        .pio_pin_i(pin), .meas_en_o(meas_en), .sleep_o(sleep),
        .pio_pull_o(pull), .pio_rdata_o(rdata)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; @(negedge clk); tick = 0; @(negedge clk);
        end
    endtask

    task automatic pio_write(logic v);
        wdata = v; wr = 1; @(negedge clk); wr = 0; @(negedge clk);
    endtask

    task automatic mode_is(string req, logic slp);
        check(req, sleep, slp);
        check({req, "/R7"}, meas_en, ~slp);
    endtask

    task automatic bus_pulse();
        bus = 0; waitc(4); bus = 1; waitc(4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        waitc(4); rst = 0; waitc(1);
        // R1 reset state
        mode_is("R1", 1'b0);
        check("R1 pull", pull, 1'b0);
        check("R1 rdata", rdata, 1'b1);

        // R8 write / readback
        pio_write(0); check("R8 pull on", pull, 1'b1);
        waitc(3); check("R8 rdata driven", rdata, 1'b0);
        pio_write(1); check("R8 pull off", pull, 1'b0);
        ext = 0; waitc(3); check("R8 rdata ext low", rdata, 1'b0);
        ext = 1; waitc(3); check("R8 rdata ext high", rdata, 1'b1);

        // R2 R3 R9 R10 bus-low sweep
        for (int pm = 0; pm < 2; pm++) begin
            for (int n = 0; n <= BL + 2; n++) begin
                pmod = pm[0];
                pio_write(0);
                bus = 0; waitc(4); ticks(n); waitc(4);
                mode_is(pm ? "R2" : "R3", (pm == 1) && (n >= BL));
                check("R9 forced release", pull, n < BL);
                if (n >= BL) begin
                    pio_write(0);
                    check("R9 write ignored", pull, 1'b0);
                end
                bus = 1; waitc(4);
                mode_is("R6 wake on edge", 1'b0);
                check("R10 stays released", pull, n < BL);
            end
        end
        pio_write(1);

        // R3 R4 undervoltage sweep
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int n = 0; n <= UV + 2; n++) begin
                logic exp;
                pmod = cfg[1]; uven = cfg[0];
                uvl = 1; waitc(4); ticks(n); waitc(4);
                exp = (cfg == 3) && (n >= UV);
                mode_is(cfg[1] ? "R4" : "R3", exp);
                if (exp) begin
                    bus_pulse();
                    mode_is("R6 edge during uv", 1'b1);
                    uvl = 0; waitc(4);
                    mode_is("R6 healthy no edge", 1'b1);
                    bus_pulse();
                    mode_is("R6 wake", 1'b0);
                end else begin
                    uvl = 0; waitc(4);
                end
            end
        end

        // R5 dwell restart
        pmod = 1; uven = 1;
        uvl = 1; waitc(4); ticks(UV - 1); uvl = 0; waitc(4);
        uvl = 1; waitc(4); ticks(UV - 1); waitc(4);
        mode_is("R5 uv restart", 1'b0);
        ticks(1); waitc(4);
        mode_is("R5 uv exact", 1'b1);
        uvl = 0; waitc(4); bus_pulse();
        mode_is("R6 wake", 1'b0);

        bus = 0; waitc(4); ticks(BL - 1); bus = 1; waitc(4);
        bus = 0; waitc(4); ticks(BL - 1); waitc(4);
        mode_is("R5 bus restart", 1'b0);
        bus = 1; waitc(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule